// File: doc/BRIEF.md
# Synchronous FIFO With Programmable Thresholds

This block is a single-clock FIFO. Its data width can be set, and its depth must be a power of two. A producer writes a word with a push strobe. A consumer removes the oldest word with a pop strobe. While the FIFO holds at least one word, that word is already present on the output bus, so reading takes no cycles of latency.

The block raises full and empty flags. It also raises two early-warning flags, near-full and near-empty, which compare the occupancy against parameters. Upstream logic can use these flags to apply back-pressure before the hard limits are reached. A flush input drops every stored word in one cycle, for use when a pipeline rolls back.

Top module: `thr_fifo`

## Requirements
- R1: After reset the FIFO is empty: `empty`=1, `full`=0, `near_empty`=1, and `near_full`=0 (for a nonzero near-full level).
- R2: Words leave in the order they were pushed. While occupancy is nonzero, `dout` shows the oldest word combinationally, with no read request.
- R3: While the FIFO is non-empty and neither pop nor flush is asserted, `dout` does not change across a clock edge.
- R4: `pop` on a non-empty FIFO removes the head word. `pop` on an empty FIFO has no effect.
- R5: `push` on a full FIFO without `pop` is dropped. The stored words and their order are unchanged.
- R6: `push` and `pop` together on a non-empty FIFO leave the occupancy unchanged, and this includes the full case. On an empty FIFO, only the push takes effect.
- R7: `full` is 1 exactly when the occupancy equals DEPTH. `empty` is 1 exactly when the occupancy is 0.
- R8: `near_full` is 1 exactly when the occupancy is at or above NF_LEVEL (default DEPTH).
- R9: `near_empty` is 1 exactly when the occupancy is at or below NE_LEVEL (default 1).
- R10: `flush` empties the FIFO in one cycle. It takes priority over any `push` or `pop` in the same cycle, and a word pushed in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all stored words |
| push | input | 1 | Write `din` at the tail |
| din | input | DATA_W | Word to write |
| pop | input | 1 | Remove the head word |
| dout | output | DATA_W | Head word, valid while `empty`=0 |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |
| near_full | output | 1 | Occupancy at or above NF_LEVEL |
| near_empty | output | 1 | Occupancy at or below NE_LEVEL |

## Verification
The assertions assume `push`, `pop` and `flush` are clean, known levels sampled at the rising edge. They do not assume the caller honours the flags. A push into a full FIFO and a pop from an empty one are treated as legal stimulus, and the assertions check that each of these is ignored. The bench drives the strobes on the falling edge. It deliberately steps past both limits in directed phases. It then runs a long pseudo-random mix of every push/pop/flush combination on a 4-entry, 8-bit build, with thresholds of 3 and 1, so that every occupancy and every flag boundary is crossed many times.

// File: rtl/thr_fifo.sv
module thr_fifo #(
  parameter int DATA_W   = 64,
  parameter int DEPTH    = 4,
  parameter int NF_LEVEL = DEPTH,
  parameter int NE_LEVEL = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] dout,
  output logic              full,
  output logic              empty,
  output logic              near_full,
  output logic              near_empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);
  localparam logic [AW:0] NF_L    = (AW+1)'(NF_LEVEL);
  localparam logic [AW:0] NE_L    = (AW+1)'(NE_LEVEL);

  logic [DATA_W-1:0] store [DEPTH];
  logic [AW:0] wptr, rptr, level;
  logic take, give;

  assign level      = wptr - rptr;
  assign empty      = (level == '0);
  assign full       = (level == DEPTH_L);
  assign near_full  = (level >= NF_L);
  assign near_empty = (level <= NE_L);
  assign dout       = store[rptr[AW-1:0]];

  assign give = pop && !empty;
  assign take = push && (!full || give);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (flush) begin
      rptr <= wptr;
    end else begin
      if (take) wptr <= wptr + 1'b1;
      if (give) rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!flush && take) store[wptr[AW-1:0]] <= din;
  end

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty); // R10
  AST_HEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !pop && !flush) |=> (!empty && $stable(dout))); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (full && $stable(dout))); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !flush) |=> empty); // R4
  AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |=> !empty); // R6
  AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && pop && !flush) |=> full); // R6
endmodule

// File: tb/thr_fifo_tb.sv
`timescale 1ns/1ps
module thr_fifo_tb;
  localparam int DW = 8, DP = 4, NF = 3, NE = 1;

  logic clk = 0, rst_n = 0, flush = 0, push = 0, pop = 0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic full, empty, near_full, near_empty;
  int vecs = 0, bad = 0;
  logic [DW-1:0] mq[$];
  string tag = "R1";

  always #2.5 clk = ~clk;

  thr_fifo #(.DATA_W(DW), .DEPTH(DP), .NF_LEVEL(NF), .NE_LEVEL(NE)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .din(din), .pop(pop),
    .dout(dout), .full(full), .empty(empty), .near_full(near_full), .near_empty(near_empty));

  task automatic chk(string r, logic [DW-1:0] act, logic [DW-1:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", r, act, exp, $time);
    end
  endtask

  task automatic compare();
    int n = mq.size();
    chk({tag, "/R7 empty"}, DW'(empty), DW'(n == 0));
    chk({tag, "/R7 full"},  DW'(full),  DW'(n == DP));
    chk({tag, "/R8 near_full"},  DW'(near_full),  DW'(n >= NF));
    chk({tag, "/R9 near_empty"}, DW'(near_empty), DW'(n <= NE));
    if (n > 0) chk({tag, "/R2 head"}, dout, mq[0]);
  endtask

  task automatic tick(logic p, logic q, logic f, logic [DW-1:0] d);
    bit gv, tk;
    push = p; pop = q; flush = f; din = d;
    @(posedge clk);
    if (f) mq.delete();                     // R10 priority
    else begin
      gv = q && mq.size() > 0;              // R4
      tk = p && (mq.size() < DP || gv);     // R5, R6
      if (gv) void'(mq.pop_front());
      if (tk) mq.push_back(d);
    end
    @(negedge clk);
    push = 0; pop = 0; flush = 0;
    compare();
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    repeat (3) @(negedge clk);
    tag = "R1"; compare();
    rst_n = 1;
    @(negedge clk);
    tag = "R4"; tick(0, 1, 0, 8'h00);       // pop empty ignored
    tag = "R6"; tick(1, 1, 0, 8'h11);       // push+pop on empty: push only
    tag = "R2";
    for (int i = 0; i < 3; i++) tick(1, 0, 0, 8'h20 + 8'(i));
    tag = "R5"; tick(1, 0, 0, 8'hEE); tick(1, 0, 0, 8'hEF);  // dropped when full
    tag = "R6"; tick(1, 1, 0, 8'h33);       // full, both: stays full
    tag = "R3"; repeat (3) tick(0, 0, 0, 8'h55);
    tag = "R4"; repeat (5) tick(0, 1, 0, 8'h00);
    tag = "R10"; tick(1, 0, 0, 8'h41); tick(1, 0, 0, 8'h42); tick(1, 1, 1, 8'h43);
    tag = "R10"; tick(1, 0, 0, 8'h44);
    tag = "R2";
    for (int i = 0; i < 6000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      tick(lf[0] | lf[1], lf[2] & (lf[3] | lf[4]), (lf[15:10] == 6'h3F), lf[11:4]);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule